// File: doc/BRIEF.md
# Rename History Rollback Buffer

This block records, for a single thread, every destination-register rename made at the rename stage. Each record holds four fields: the instruction's sequence number, the architectural register it writes, the physical register it was just given, and the physical register that previously held that architectural register. The records are kept in program order in a circular store. The rename table and the free list are outside the block. The block drives them through two write strobes: one restores a map entry, the other hands a physical register back to the free list.

A squash request names a sequence number. Starting from the youngest record, the block undoes each record that is younger than that number. It writes the old physical register back into the map and frees the new one. A commit request also names a sequence number. Starting from the oldest record, the block retires each record that is no younger than that number. It frees the superseded physical register and advances a count of committed maps.

Some architectural registers are never really renamed, such as a hard-wired zero register. Records for these carry identical new and previous physical registers. The block removes such records but never restores or frees anything for them. It handles one record per clock and holds a busy flag while a walk is in progress.

Top module: `rename_history_buffer`

## Requirements
- R1: A push is stored only when `pushValid` is high, `full` is low, `busy` is low and neither `squashValid` nor `commitValid` is high in that cycle. `full` is high while DEPTH records are held. A push made while full, or while busy, leaves the contents unchanged.
- R2: A squash removes records from the youngest backward while the record's sequence number is strictly greater than `squashSeq`, compared unsigned. It stops at the first record that is not greater, or when the store is empty.
- R3: Undoing a record whose new and previous physical registers differ does two things in the cycle after that record is processed. It pulses `mapWrEn` with `mapWrArch` = architectural register and `mapWrPhys` = previous physical register. It also pulses `freeEn` with `freePhys` = new physical register.
- R4: A squashed record whose new and previous physical registers are equal produces neither a map write nor a free, but it is still removed.
- R5: A commit removes records from the oldest forward while the record's sequence number is less than or equal to `commitSeq`. Each removed record with differing registers pulses `freeEn` with `freePhys` = previous physical register. A commit never pulses `mapWrEn`.
- R6: A committed record whose new and previous physical registers are equal produces no free, but it is still removed.
- R7: `committedCount` increases by exactly one for every committed record, including records with equal registers. Squashed records do not change it.
- R8: A walk handles one record per clock. `busy` is high from the cycle after the request is taken until the clock on which the walk finds no qualifying record, so a walk that removes k records keeps `busy` high for k+1 cycles. Squash and commit requests made while `busy` is high are ignored.
- R9: When `squashValid` and `commitValid` are both high in an idle cycle, only the squash is performed.
- R10: After reset the store is empty, `busy`, `full`, `mapWrEn` and `freeEn` are low, and `committedCount` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | New rename record offered |
| pushSeq | input | SEQ_W | Sequence number of the new record |
| pushArch | input | ARCH_W | Architectural destination register |
| pushNewPhys | input | PHYS_W | Newly assigned physical register |
| pushPrevPhys | input | PHYS_W | Physical register being replaced |
| squashValid | input | 1 | Squash request, one-cycle pulse |
| squashSeq | input | SEQ_W | Records younger than this are undone |
| commitValid | input | 1 | Commit request, one-cycle pulse |
| commitSeq | input | SEQ_W | Records up to this number are retired |
| mapWrEn | output | 1 | Map restore strobe |
| mapWrArch | output | ARCH_W | Architectural register to restore |
| mapWrPhys | output | PHYS_W | Physical register written back into the map |
| freeEn | output | 1 | Free-list return strobe |
| freePhys | output | PHYS_W | Physical register returned |
| committedCount | output | CNT_W | Number of committed records |
| busy | output | 1 | Walk in progress |
| full | output | 1 | No free slot |

## Verification
The hardest situations to reach from the ports are inputs that arrive while a walk is running. The stimulus issues a squash that must remove several records. During the following busy cycle it drives a commit request and a push together, and both must leave no trace. It then measures how long `busy` stays high. Records with equal registers are placed at both ends of the store, so that both the squash walk and the commit walk meet one and must skip the strobes while still counting the record or removing it.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walkState_t;

  typedef struct packed {
    logic push;
    logic popYoung;
    logic popOld;
  } rhbStrobe_t;
endpackage

// File: rtl/rhb_datapath.sv
module rhb_datapath
  import rhb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rhbStrobe_t        strobe,
  input  logic [SEQ_W-1:0]  pushSeq,
  input  logic [ARCH_W-1:0] pushArch,
  input  logic [PHYS_W-1:0] pushNewPhys,
  input  logic [PHYS_W-1:0] pushPrevPhys,
  output logic [SEQ_W-1:0]  youngSeq,
  output logic [SEQ_W-1:0]  oldSeq,
  output logic              empty,
  output logic              full,
  output logic              mapWrEn,
  output logic [ARCH_W-1:0] mapWrArch,
  output logic [PHYS_W-1:0] mapWrPhys,
  output logic              freeEn,
  output logic [PHYS_W-1:0] freePhys,
  output logic [CNT_W-1:0]  committedCount
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_MAX  = OCC_W'(DEPTH);

  logic [SEQ_W-1:0]  seqMem  [DEPTH];
  logic [ARCH_W-1:0] archMem [DEPTH];
  logic [PHYS_W-1:0] newMem  [DEPTH];
  logic [PHYS_W-1:0] prevMem [DEPTH];

  logic [PTR_W-1:0] headPtr, tailPtr, youngIdx;
  logic [OCC_W-1:0] occupancy;
  logic             youngRenamed, oldRenamed;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign youngIdx     = (tailPtr == '0) ? LAST_IDX : tailPtr - 1'b1;
  assign youngSeq     = seqMem[youngIdx];
  assign oldSeq       = seqMem[headPtr];
  assign empty        = (occupancy == '0);
  assign full         = (occupancy == OCC_MAX);
  assign youngRenamed = (newMem[youngIdx] != prevMem[youngIdx]);
  assign oldRenamed   = (newMem[headPtr] != prevMem[headPtr]);

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      seqMem[tailPtr]  <= pushSeq;
      archMem[tailPtr] <= pushArch;
      newMem[tailPtr]  <= pushNewPhys;
      prevMem[tailPtr] <= pushPrevPhys;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr        <= '0;
      tailPtr        <= '0;
      occupancy      <= '0;
      mapWrEn        <= 1'b0;
      mapWrArch      <= '0;
      mapWrPhys      <= '0;
      freeEn         <= 1'b0;
      freePhys       <= '0;
      committedCount <= '0;
    end else begin
      mapWrEn <= 1'b0;
      freeEn  <= 1'b0;
      if (strobe.push) begin
        tailPtr   <= nextPtr(tailPtr);
        occupancy <= occupancy + 1'b1;
      end else if (strobe.popYoung) begin
        tailPtr   <= youngIdx;
        occupancy <= occupancy - 1'b1;
        mapWrEn   <= youngRenamed;
        mapWrArch <= archMem[youngIdx];
        mapWrPhys <= prevMem[youngIdx];
        freeEn    <= youngRenamed;
        freePhys  <= newMem[youngIdx];
      end else if (strobe.popOld) begin
        headPtr        <= nextPtr(headPtr);
        occupancy      <= occupancy - 1'b1;
        freeEn         <= oldRenamed;
        freePhys       <= prevMem[headPtr];
        committedCount <= committedCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rhb_control.sv
module rhb_control
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushValid,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             empty,
  input  logic             full,
  input  logic [SEQ_W-1:0] youngSeq,
  input  logic [SEQ_W-1:0] oldSeq,
  output rhbStrobe_t       strobe,
  output logic             busy
);
  walkState_t       state, stateNext;
  logic [SEQ_W-1:0] boundSeq;
  logic             youngHit, oldHit;

  assign busy     = (state != WALK_IDLE);
  assign youngHit = !empty && (youngSeq > boundSeq);
  assign oldHit   = !empty && (oldSeq <= boundSeq);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      WALK_IDLE: begin
        if (squashValid)      stateNext = WALK_SQUASH;
        else if (commitValid) stateNext = WALK_COMMIT;
        else                  strobe.push = pushValid && !full;
      end
      WALK_SQUASH: begin
        if (youngHit) strobe.popYoung = 1'b1;
        else          stateNext = WALK_IDLE;
      end
      WALK_COMMIT: begin
        if (oldHit) strobe.popOld = 1'b1;
        else        stateNext = WALK_IDLE;
      end
      default: stateNext = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= WALK_IDLE;
      boundSeq <= '0;
    end else begin
      state <= stateNext;
      if (state == WALK_IDLE) begin
        if (squashValid)      boundSeq <= squashSeq;
        else if (commitValid) boundSeq <= commitSeq;
      end
    end
  end
endmodule

// File: rtl/rename_history_buffer.sv
module rename_history_buffer
  import rhb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushValid,
  input  logic [SEQ_W-1:0]  pushSeq,
  input  logic [ARCH_W-1:0] pushArch,
  input  logic [PHYS_W-1:0] pushNewPhys,
  input  logic [PHYS_W-1:0] pushPrevPhys,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  output logic              mapWrEn,
  output logic [ARCH_W-1:0] mapWrArch,
  output logic [PHYS_W-1:0] mapWrPhys,
  output logic              freeEn,
  output logic [PHYS_W-1:0] freePhys,
  output logic [CNT_W-1:0]  committedCount,
  output logic              busy,
  output logic              full
);
  rhbStrobe_t       strobe;
  logic             empty;
  logic [SEQ_W-1:0] youngSeq, oldSeq;

  rhb_control #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .empty(empty), .full(full), .youngSeq(youngSeq), .oldSeq(oldSeq),
    .strobe(strobe), .busy(busy)
  );

  rhb_datapath #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
    .PHYS_W(PHYS_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .pushSeq(pushSeq), .pushArch(pushArch),
    .pushNewPhys(pushNewPhys), .pushPrevPhys(pushPrevPhys),
    .youngSeq(youngSeq), .oldSeq(oldSeq), .empty(empty), .full(full),
    .mapWrEn(mapWrEn), .mapWrArch(mapWrArch), .mapWrPhys(mapWrPhys),
    .freeEn(freeEn), .freePhys(freePhys), .committedCount(committedCount)
  );
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
  parameter int PHYS_W = 7,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mapWrEn,
  input logic [PHYS_W-1:0] mapWrPhys,
  input logic              freeEn,
  input logic [PHYS_W-1:0] freePhys,
  input logic [CNT_W-1:0]  committedCount
);
  // R3: a map restore always comes with the return of the new register
  a_r3_restore_frees: assert property (@(posedge clk) disable iff (!rst_n)
    mapWrEn |-> freeEn);

  // R4: a restored record never has equal old and new registers
  a_r4_no_identity_restore: assert property (@(posedge clk) disable iff (!rst_n)
    mapWrEn |-> (mapWrPhys != freePhys));

  // R8: strobes only follow a cycle in which a walk was running
  a_r8_strobe_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (mapWrEn || freeEn) |-> $past(busy));

  // R7: the committed count moves by one at a time
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (committedCount != $past(committedCount)) |->
      (committedCount == $past(committedCount) + 1'b1));

  // R7: the count only moves after a walk cycle
  a_r7_count_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (committedCount != $past(committedCount)) |-> $past(busy));
endmodule

bind rename_history_buffer rhb_checker #(.PHYS_W(PHYS_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_rename_history_buffer.sv
module tb_rename_history_buffer;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pushValid = 1'b0;
  logic [15:0] pushSeq = '0;
  logic [4:0]  pushArch = '0;
  logic [6:0]  pushNewPhys = '0, pushPrevPhys = '0;
  logic        squashValid = 1'b0, commitValid = 1'b0;
  logic [15:0] squashSeq = '0, commitSeq = '0;
  logic        mapWrEn, freeEn, busy, full;
  logic [4:0]  mapWrArch;
  logic [6:0]  mapWrPhys, freePhys;
  logic [15:0] committedCount;

  rename_history_buffer dut (.*);

  always #5 clk = ~clk;

  typedef struct {int seq; int arch; int nw; int pv;} ent_t;
  ent_t model[$];
  int   restArchQ[$], restPhysQ[$], freeQ[$];
  int   expCount = 0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compare strobes against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mapWrEn) begin
        if (restArchQ.size() == 0) check("R3", 1, 0, "unexpected map write");
        else begin
          check("R3", int'(mapWrArch), restArchQ.pop_front(), "map arch");
          check("R3", int'(mapWrPhys), restPhysQ.pop_front(), "map phys");
        end
      end
      if (freeEn) begin
        if (freeQ.size() == 0) check("R5", 1, 0, "unexpected free");
        else check("R5", int'(freePhys), freeQ.pop_front(), "free phys");
      end
    end
  end

  task automatic drive(input bit pv, input int s, input int a, input int n, input int p,
                       input bit sv, input int ss, input bit cv, input int cs);
    @(negedge clk);
    pushValid = pv; pushSeq = 16'(s); pushArch = 5'(a);
    pushNewPhys = 7'(n); pushPrevPhys = 7'(p);
    squashValid = sv; squashSeq = 16'(ss);
    commitValid = cv; commitSeq = 16'(cs);
    @(posedge clk); #1;
    pushValid = 0; squashValid = 0; commitValid = 0;
  endtask

  task automatic push(input int s, input int a, input int n, input int p);
    if (model.size() < DEPTH) model.push_back('{s, a, n, p});
    drive(1, s, a, n, p, 0, 0, 0, 0);
  endtask

  task automatic modelSquash(input int s);
    while (model.size() > 0 && model[$].seq > s) begin
      ent_t e = model.pop_back();
      if (e.nw != e.pv) begin
        restArchQ.push_back(e.arch); restPhysQ.push_back(e.pv); freeQ.push_back(e.nw);
      end
    end
  endtask

  task automatic modelCommit(input int s);
    while (model.size() > 0 && model[0].seq <= s) begin
      ent_t e = model.pop_front();
      if (e.nw != e.pv) freeQ.push_back(e.pv);
      expCount++;
    end
  endtask

  // wait for the walk to finish, return busy cycles
  task automatic waitIdle(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
  endtask

  task automatic endOp(input string req);
    check(req, restArchQ.size() + freeQ.size(), 0, "expected strobes left over");
    check("R7", int'(committedCount), expCount, "committed count");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, pre;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10", busy, 0, "busy"); check("R10", full, 0, "full");
    check("R10", mapWrEn, 0, "mapWrEn"); check("R10", freeEn, 0, "freeEn");
    check("R10", int'(committedCount), 0, "count");

    // R1 fill to full; seq 12 is an identity record
    for (int i = 0; i < 8; i++)
      push(10 + i, i + 1, 40 + i, (i == 2) ? 40 + i : 20 + i);
    @(negedge clk);
    check("R1", full, 1, "full after DEPTH pushes");
    push(18, 9, 99, 98);               // ignored: full
    check("R1", full, 1, "still full");

    // R5 commit 11: retires 10, 11
    modelCommit(11); drive(0,0,0,0,0, 0,0, 1,11); waitIdle(n);
    check("R8", n, 3, "commit busy cycles");
    endOp("R5");
    check("R1", full, 0, "not full after commit");

    // R2 squash 14: removes 17,16,15; 14 stays
    modelSquash(14); drive(0,0,0,0,0, 1,14, 0,0); waitIdle(n);
    check("R8", n, 4, "squash busy cycles");
    endOp("R2");

    // R6 commit 13: retires 12 (identity, no free) and 13
    modelCommit(13); drive(0,0,0,0,0, 0,0, 1,13); waitIdle(n);
    endOp("R6");
    check("R7", int'(committedCount), 4, "identity record counted");

    // R9 both requests: squash wins
    push(20, 3, 60, 61); push(21, 4, 62, 63); push(22, 5, 64, 65); push(23, 6, 66, 67);
    modelSquash(21); drive(0,0,0,0,0, 1,21, 1,30); waitIdle(n);
    endOp("R9");
    check("R9", int'(committedCount), 4, "commit not done alongside squash");

    // R8 requests and pushes while busy are ignored
    pre = int'(committedCount);
    modelSquash(14); drive(0,0,0,0,0, 1,14, 0,0);
    drive(1, 50, 7, 70, 71, 0,0, 1,100);   // during busy: both ignored
    waitIdle(n);
    endOp("R8");
    check("R8", int'(committedCount), pre, "commit while busy ignored");

    // R4 identity record at the young end, then empty the store
    push(30, 8, 44, 44);
    modelSquash(0); drive(0,0,0,0,0, 1,0, 0,0); waitIdle(n);
    check("R4", n, 3, "identity record still removed");
    endOp("R4");
    // store is now empty: a squash removes nothing
    drive(0,0,0,0,0, 1,0, 0,0); waitIdle(n);
    check("R2", n, 1, "squash on empty store");

    // R5 commit all of two new records (push while busy above left nothing)
    push(40, 1, 80, 81); push(41, 2, 82, 83);
    modelCommit(100); drive(0,0,0,0,0, 0,0, 1,100); waitIdle(n);
    check("R8", n, 3, "final commit busy cycles");
    endOp("R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule